// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Protected Memory

This block wraps a small synchronous RAM so that every stored byte carries a protection code. On a write, four Hamming check bits and one overall parity bit are computed from the 8 data bits, and all 13 bits are written into the array as one codeword. On a read, the fetched codeword is checked again. The block then returns the data as it was fetched, returns data repaired by a single-bit corrector, or raises an uncorrectable flag.

The read side is organised around a small outcome state machine. `ST_IDLE` is the state after reset, before any read. Each read enable moves the machine to `ST_CLEAN`, `ST_FIXED` or `ST_FATAL`, according to what the decoder found in the addressed word. With no read enable the machine stays in its state, so the flags keep the outcome of the most recent read. The transitions are: IDLE/any state to CLEAN on a read of a valid codeword; to FIXED on a read with one flipped bit; to FATAL on a read with two flipped bits; and a self-loop when there is no read. A test-only injection mask is XORed into the codeword on its way into the array, so that a bench can plant faults.

Top module: `secded_mem_path`

## Requirements
- R1: A write stores a 13-bit codeword. Bit 0 is the even parity of bits 12..1. Bits 1, 2, 4 and 8 are check bits. Data bits 0..7 sit at bits 3, 5, 6, 7, 9, 10, 11 and 12. Check bit 2^j is the XOR of the data bits whose position has bit j set.
- R2: A read of an undamaged word returns the written data with `corrected_o` and `uncorrectable_o` both low.
- R3: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and low in every other cycle.
- R4: If exactly one of the 13 stored bits is flipped, including a check bit or the parity bit, the read returns the originally written data with `corrected_o`=1 and `uncorrectable_o`=0.
- R5: If exactly two stored bits are flipped, the read sets `uncorrectable_o`=1 and `corrected_o`=0, and returns the fetched data bits unmodified. The two flags are never high together.
- R6: `rd_data`, `corrected_o` and `uncorrectable_o` hold their values until the next read.
- R7: Bit i of `err_inject` inverts bit i of the codeword (layout of R1) as it is written. A zero mask leaves the word undamaged.
- R8: If a read and a write address the same word in the same cycle, the read returns the old contents.
- R9: After reset, `rd_valid`, `rd_data`, `corrected_o` and `uncorrectable_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| err_inject | input | 13 | Test-only fault mask XORed into the written codeword |
| rd_en | input | 1 | Read enable |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data (corrected when possible) |
| rd_valid | output | 1 | One-cycle pulse one clock after a read |
| corrected_o | output | 1 | Last read had a single-bit error that was repaired |
| uncorrectable_o | output | 1 | Last read had a double-bit error |

## Verification
Faulty codewords cannot appear at the ports on their own, because every normal write stores a valid code. Reaching the FIXED and FATAL outcomes therefore depends on the injection mask. The random stimulus writes words with masks of zero, one or two set bits, at positions spread over all 13 codeword bits, and reads them back at random. A reference encoder in the bench predicts the repaired data and the raw data. Directed cases cover a flipped parity bit, a flipped check bit, and a read and a write that hit the same word together.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int HPOS   = DATA_W + CHK_W;   // highest Hamming position
    localparam int CW_W   = HPOS + 1;         // plus overall parity at bit 0

    typedef enum logic [1:0] {
        RES_CLEAN,
        RES_FIXED,
        RES_FATAL
    } chk_res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAN,
        ST_FIXED,
        ST_FATAL
    } rd_state_e;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // XOR of the positions of all set bits among Hamming positions 1..HPOS
    function automatic logic [CHK_W-1:0] syndrome(input logic [CW_W-1:0] cw);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 1; p <= HPOS; p++) begin
            if (cw[p]) s = s ^ CHK_W'(p);
        end
        return s;
    endfunction

    function automatic logic [CW_W-1:0] encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0]  cw;
        logic [CHK_W-1:0] s;
        int               k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= HPOS; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[k];
                k++;
            end
        end
        s = syndrome(cw);
        for (int j = 0; j < CHK_W; j++) cw[1 << j] = s[j];
        cw[0] = ^cw[HPOS:1];
        return cw;
    endfunction

    function automatic logic [DATA_W-1:0] extract(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int                k;
        d = '0;
        k = 0;
        for (int p = 1; p <= HPOS; p++) begin
            if (!is_pow2(p)) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/secded_encode.sv
module secded_encode
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CW_W-1:0]   flip_i,
    output logic [CW_W-1:0]   cw_o
);
    // R1 layout built by encode(); R7 fault mask applied on the way in
    assign cw_o = encode(data_i) ^ flip_i;
endmodule

// File: rtl/secded_store.sv
module secded_store
    import secded_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [CW_W-1:0] wcw_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [CW_W-1:0] rcw_o
);
    logic [CW_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wcw_i;
    end

    // asynchronous fetch; the caller registers the decoded result, so a
    // same-edge write is not yet visible (R8)
    assign rcw_o = mem_q[raddr_i];
endmodule

// File: rtl/secded_check.sv
module secded_check
    import secded_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output chk_res_e          res_o
);
    logic [CHK_W-1:0] syn;
    logic             par_bad;
    logic [CW_W-1:0]  repaired;

    always_comb begin
        syn      = syndrome(cw_i);
        par_bad  = ^cw_i;
        repaired = cw_i;
        if (!par_bad && syn == '0) begin
            res_o = RES_CLEAN;
        end else if (par_bad && int'(syn) <= HPOS) begin
            res_o = RES_FIXED;
            if (syn == '0) begin
                repaired[0] = ~repaired[0];
            end else begin
                for (int p = 1; p <= HPOS; p++) begin
                    if (int'(syn) == p) repaired[p] = ~repaired[p];
                end
            end
        end else begin
            res_o = RES_FATAL;
        end
        data_o = extract(repaired);
    end

    // R4: a repaired word must be a valid codeword again
    always_comb begin
        if (res_o == RES_FIXED) begin
            a_r4_repair_valid: assert (syndrome(repaired) == '0 && (^repaired) == 1'b0);
        end
    end
endmodule

// File: rtl/secded_mem_path.sv
module secded_mem_path
    import secded_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CW_W-1:0]   err_inject,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              corrected_o,
    output logic              uncorrectable_o
);
    logic [CW_W-1:0]   wr_cw;
    logic [CW_W-1:0]   rd_cw;
    logic [DATA_W-1:0] dec_data;
    chk_res_e          dec_res;
    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    secded_encode u_enc (
        .data_i (wr_data),
        .flip_i (err_inject),
        .cw_o   (wr_cw)
    );

    secded_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (wr_addr),
        .wcw_i   (wr_cw),
        .raddr_i (rd_addr),
        .rcw_o   (rd_cw)
    );

    secded_check u_chk (
        .cw_i   (rd_cw),
        .data_o (dec_data),
        .res_o  (dec_res)
    );

    always_comb begin
        state_d = state_q;
        if (rd_en) begin
            unique case (dec_res)
                RES_CLEAN: state_d = ST_CLEAN;
                RES_FIXED: state_d = ST_FIXED;
                RES_FATAL: state_d = ST_FATAL;
                default:   state_d = ST_FATAL;
            endcase
        end
    end

    // state register (and the data held with it)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= rd_en;
            if (rd_en) data_q <= dec_data;
        end
    end

    // outputs
    always_comb begin
        corrected_o     = 1'b0;
        uncorrectable_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CLEAN: ;
            ST_FIXED: corrected_o     = 1'b1;
            ST_FATAL: uncorrectable_o = 1'b1;
            default:  ;
        endcase
    end

    assign rd_data  = data_q;
    assign rd_valid = valid_q;

    a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(corrected_o) && $stable(uncorrectable_o)));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected_o && uncorrectable_o));
endmodule

// File: tb/test_secded_mem_path.sv
`timescale 1ns/1ps
module test_secded_mem_path;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int CWW   = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [CWW-1:0] err_inject;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          rd_valid, corrected_o, uncorrectable_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // bench model
    logic [7:0]     m_data [DEPTH];
    logic [CWW-1:0] m_cw   [DEPTH];
    int             m_wt   [DEPTH];

    always #10 clk = ~clk;  // 50 MHz

    secded_mem_path #(.DEPTH(DEPTH)) i_secded_mem_path (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .err_inject(err_inject), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .corrected_o(corrected_o), .uncorrectable_o(uncorrectable_o)
    );

    // data bit k sits at codeword bit dpos(k) (R1)
    function automatic int dpos(input int k);
        case (k)
            0: return 3;   1: return 5;   2: return 6;  3: return 7;
            4: return 9;   5: return 10;  6: return 11; default: return 12;
        endcase
    endfunction

    function automatic logic [CWW-1:0] ref_encode(input logic [7:0] d);
        logic [CWW-1:0] cw;
        cw = '0;
        for (int k = 0; k < 8; k++) cw[dpos(k)] = d[k];
        for (int j = 0; j < 4; j++) begin
            logic c;
            c = 1'b0;
            for (int k = 0; k < 8; k++) if ((dpos(k) >> j) & 1) c = c ^ d[k];
            cw[1 << j] = c;
        end
        cw[0] = ^cw[12:1];
        return cw;
    endfunction

    function automatic logic [7:0] ref_extract(input logic [CWW-1:0] cw);
        logic [7:0] d;
        for (int k = 0; k < 8; k++) d[k] = cw[dpos(k)];
        return d;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input logic [CWW-1:0] mask);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; err_inject = mask;
        @(negedge clk);
        wr_en = 1'b0; err_inject = '0;
        m_data[a] = d;
        m_cw[a]   = ref_encode(d) ^ mask;
        m_wt[a]   = $countones(mask);
    endtask

    // read and compare against model of address a
    task automatic do_read(input int a, input string tag);
        logic [7:0] exp_d;
        int exp_c, exp_u;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        exp_c = 0; exp_u = 0;
        if (m_wt[a] == 0) exp_d = m_data[a];
        else if (m_wt[a] == 1) begin exp_d = m_data[a]; exp_c = 1; end
        else begin exp_d = ref_extract(m_cw[a]); exp_u = 1; end
        check({tag, " R3 valid"}, int'(rd_valid), 1);
        check({tag, " data"}, int'(rd_data), int'(exp_d));
        check({tag, " corrected"}, int'(corrected_o), exp_c);
        check({tag, " uncorrectable"}, int'(uncorrectable_o), exp_u);
    endtask

    function automatic logic [CWW-1:0] rand_mask(input int wt);
        logic [CWW-1:0] m;
        int p, q;
        m = '0;
        if (wt >= 1) begin p = int'($urandom_range(12, 0)); m[p] = 1'b1; end
        if (wt >= 2) begin
            q = int'($urandom_range(11, 0));
            if (q >= p) q++;
            m[q] = 1'b1;
        end
        return m;
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] hd;
        logic hc, hu;
        void'($urandom(32'd4242));
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; wr_data = '0; err_inject = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 valid", int'(rd_valid), 0);
        check("R9 data", int'(rd_data), 0);
        check("R9 corrected", int'(corrected_o), 0);
        check("R9 uncorrectable", int'(uncorrectable_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 idle valid", int'(rd_valid), 0);

        for (int a = 0; a < DEPTH; a++) do_write(a, 8'(a * 37 + 5), '0);

        // R1/R4: byte 0x39, data bit 3 (codeword bit 7) flipped
        do_write(1, 8'h39, 13'h0080);
        do_read(1, "R1 R4 data-bit fix");
        // R4: overall parity bit flipped
        do_write(2, 8'hA5, 13'h0001);
        do_read(2, "R4 parity-bit fix");
        // R4: check bit at position 8 flipped
        do_write(3, 8'h5A, 13'h0100);
        do_read(3, "R4 check-bit fix");
        // R5: two bits flipped
        do_write(4, 8'hC3, 13'h0220);
        do_read(4, "R5 double");
        // R7/R2: zero mask gives clean read
        do_write(5, 8'hFF, '0);
        do_read(5, "R2 R7 clean");

        // R6: outputs held while idle
        do_read(4, "R6 setup");
        hd = rd_data; hc = corrected_o; hu = uncorrectable_o;
        repeat (3) @(negedge clk);
        check("R3 pulse ended", int'(rd_valid), 0);
        check("R6 data held", int'(rd_data), int'(hd));
        check("R6 corrected held", int'(corrected_o), int'(hc));
        check("R6 uncorrectable held", int'(uncorrectable_o), int'(hu));

        // R8: read and write same word together returns old contents
        do_write(6, 8'h12, '0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(6); wr_data = 8'h34; err_inject = 13'h0003;
        rd_en = 1'b1; rd_addr = AW'(6);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; err_inject = '0;
        check("R8 old data", int'(rd_data), 8'h12);
        check("R8 old clean", int'(uncorrectable_o), 0);
        m_data[6] = 8'h34; m_cw[6] = ref_encode(8'h34) ^ 13'h0003; m_wt[6] = 2;
        do_read(6, "R8 new contents R5");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int a, wt;
            a = int'($urandom_range(DEPTH - 1, 0));
            if ($urandom_range(1, 0) == 0) begin
                wt = int'($urandom_range(2, 0));
                do_write(a, 8'($urandom), rand_mask(wt));
            end else begin
                do_read(a, "R2 R4 R5 random");
            end
        end

        finish_run();
    end
endmodule